// File: doc/BRIEF.md
# Three-Process Synchronous Dataflow Network

This block is a small clocked network of three cooperating integer processes that all react together on one clock edge whenever the reaction-enable input is high. A producer of a boolean flag (`w`) watches two integer streams (`y`, `z`). A second process produces an odd-number ramp (`x`) and a stream derived from it (`y`). A third process produces `z` from a two-reaction-old copy of `x`. Every signal is present at every reaction, so all four are updated together. Each process counts its own completed reactions and uses that count to choose its start-up values. It also keeps delayed copies of the inputs its recurrence reads.

All four signals leave the block as registered outputs every cycle. A testbench or a neighbouring block can then follow the network reaction by reaction. Dropping the enable freezes the whole network, history registers included, so that a later reaction carries on exactly where the previous one stopped. Integer streams are 16-bit two's complement by default and wrap on overflow.

Top module: `dfn_net`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) puts the network in reaction 0: `w_o`=1, `x_o`=1, `y_o`=0, `z_o`=0, and clears every reaction counter and history register.
- R2: At each enabled reaction, `x_o` becomes its previous value plus 2.
- R3: At each enabled reaction, `y_o` becomes the previous `x_o` plus 1 if the previous `w_o` was 1, and the previous `x_o` minus 1 otherwise.
- R4: At each enabled reaction, `w_o` becomes 1 exactly when the previous `y_o` is greater than the previous `z_o`, with both compared as signed values.
- R5: `z_o` is 0 at reactions 0 and 1. From reaction 2 on, it equals the `x_o` of two reactions earlier minus 3 if the previous `w_o` was 1, and that `x_o` plus 3 otherwise.
- R6: While `react_en` is low, all four outputs and all internal history hold their values. The reactions that follow continue the sequence as if the frozen cycles had not occurred.
- R7: Starting from reset, reactions 0 to 7 give `w_o` = 1,0,1,0,1,0,1,0; `x_o` = 1,3,5,7,9,11,13,15; `y_o` = 0,2,2,6,6,10,10,14; `z_o` = 0,0,4,0,8,4,12,8.
- R8: Integer arithmetic wraps modulo 2^16, so `x_o` steps from 32767 to -32767 (16'h8001).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; one reaction per enabled rising edge |
| rst | input | 1 | Synchronous active-high reset to reaction 0 |
| react_en | input | 1 | Reaction enable; low freezes the entire network |
| w_o | output | 1 | Boolean flag produced by process P |
| x_o | output | 16 | Signed ramp produced by process Q |
| y_o | output | 16 | Signed stream produced by process Q |
| z_o | output | 16 | Signed stream produced by process R |

## Verification
Each output is one register deep, so a reaction started by an enabled clock edge shows on all four ports just after that same edge. `z_o` depends on `x_o` from one reaction further back, which is held in an internal history register. The bench drives `react_en` on the falling edge and samples one time unit after the next rising edge, so each check sees exactly one new reaction. After every reaction it compares against a reference recurrence, and after every frozen cycle it compares against the unchanged previous values. The run continues past the point where `x_o` overflows, so the signed comparison and the wrap are also exercised.

// File: rtl/dfn_pkg.sv
package dfn_pkg;

   localparam int DFN_DATA_W = 16;

   // True when the reaction that follows a count of done_cnt completed
   // reactions still lies inside the start-up window of length init_len.
   function automatic logic startup_next(input int unsigned done_cnt,
                                         input int unsigned init_len);
      return (done_cnt + 1) < init_len;
   endfunction

endpackage

// File: rtl/dfn_tap.sv
module dfn_tap #(
   parameter int DATA_W = 16,
   parameter int DEPTH  = 1
) (
   input  logic                     clk,
   input  logic                     rst,
   input  logic                     en,
   input  logic signed [DATA_W-1:0] d_i,
   output logic signed [DATA_W-1:0] q_o
);

   logic signed [DATA_W-1:0] stage_q [DEPTH];

   always_ff @(posedge clk) begin
      if (rst) begin
         for (int i = 0; i < DEPTH; i++) stage_q[i] <= '0;
      end else if (en) begin
         stage_q[0] <= d_i;
         for (int i = 1; i < DEPTH; i++) stage_q[i] <= stage_q[i-1];
      end
   end

   assign q_o = stage_q[DEPTH-1];

endmodule

// File: rtl/dfn_proc_p.sv
module dfn_proc_p #(
   parameter int   DATA_W   = 16,
   parameter int   INIT_LEN = 1,
   parameter logic W_INIT   = 1'b1
) (
   input  logic                     clk,
   input  logic                     rst,
   input  logic                     en,
   input  logic signed [DATA_W-1:0] y_i,
   input  logic signed [DATA_W-1:0] z_i,
   output logic                     w_o
);

   localparam int CNT_W = $clog2(INIT_LEN + 1);

   logic [CNT_W-1:0] cnt_q;
   logic             w_q;
   logic             boot_next;

   assign boot_next = dfn_pkg::startup_next(int'(cnt_q), INIT_LEN);

   always_ff @(posedge clk) begin
      if (rst) begin
         cnt_q <= '0;
         w_q   <= W_INIT;
      end else if (en) begin
         if (cnt_q != CNT_W'(INIT_LEN)) cnt_q <= cnt_q + 1'b1;
         w_q <= boot_next ? W_INIT : (y_i > z_i);
      end
   end

   assign w_o = w_q;

endmodule

// File: rtl/dfn_proc_q.sv
module dfn_proc_q #(
   parameter int DATA_W   = 16,
   parameter int INIT_LEN = 1,
   parameter int X_INIT   = 1,
   parameter int X_STEP   = 2,
   parameter int Y_INIT   = 0,
   parameter int Y_STEP   = 1
) (
   input  logic                     clk,
   input  logic                     rst,
   input  logic                     en,
   input  logic                     w_i,
   output logic signed [DATA_W-1:0] x_o,
   output logic signed [DATA_W-1:0] y_o
);

   localparam int CNT_W = $clog2(INIT_LEN + 1);
   localparam logic signed [DATA_W-1:0] X0_V  = DATA_W'(X_INIT);
   localparam logic signed [DATA_W-1:0] XS_V  = DATA_W'(X_STEP);
   localparam logic signed [DATA_W-1:0] Y0_V  = DATA_W'(Y_INIT);
   localparam logic signed [DATA_W-1:0] YS_V  = DATA_W'(Y_STEP);

   logic [CNT_W-1:0]         cnt_q;
   logic signed [DATA_W-1:0] x_q;
   logic signed [DATA_W-1:0] y_q;
   logic                     boot_next;

   assign boot_next = dfn_pkg::startup_next(int'(cnt_q), INIT_LEN);

   always_ff @(posedge clk) begin
      if (rst) begin
         cnt_q <= '0;
         x_q   <= X0_V;
         y_q   <= Y0_V;
      end else if (en) begin
         if (cnt_q != CNT_W'(INIT_LEN)) cnt_q <= cnt_q + 1'b1;
         x_q <= x_q + XS_V;
         if (boot_next) y_q <= Y0_V;
         else           y_q <= w_i ? (x_q + YS_V) : (x_q - YS_V);
      end
   end

   assign x_o = x_q;
   assign y_o = y_q;

endmodule

// File: rtl/dfn_proc_r.sv
module dfn_proc_r #(
   parameter int DATA_W   = 16,
   parameter int INIT_LEN = 2,
   parameter int Z_INIT   = 0,
   parameter int Z_OFFSET = 3,
   parameter int Z_LAG    = 2
) (
   input  logic                     clk,
   input  logic                     rst,
   input  logic                     en,
   input  logic                     w_i,
   input  logic signed [DATA_W-1:0] x_i,
   output logic signed [DATA_W-1:0] z_o
);

   localparam int CNT_W = $clog2(INIT_LEN + 1);
   localparam logic signed [DATA_W-1:0] Z0_V  = DATA_W'(Z_INIT);
   localparam logic signed [DATA_W-1:0] OFS_V = DATA_W'(Z_OFFSET);

   logic [CNT_W-1:0]         cnt_q;
   logic signed [DATA_W-1:0] z_q;
   logic signed [DATA_W-1:0] x_old;
   logic                     boot_next;

   // x_i already carries the previous reaction's x; deeper lags need a tap line.
   generate
      if (Z_LAG == 1) begin : g_no_tap
         assign x_old = x_i;
      end else begin : g_tap
         dfn_tap #(.DATA_W(DATA_W), .DEPTH(Z_LAG - 1)) u_tap (
            .clk (clk),
            .rst (rst),
            .en  (en),
            .d_i (x_i),
            .q_o (x_old)
         );
      end
   endgenerate

   assign boot_next = dfn_pkg::startup_next(int'(cnt_q), INIT_LEN);

   always_ff @(posedge clk) begin
      if (rst) begin
         cnt_q <= '0;
         z_q   <= Z0_V;
      end else if (en) begin
         if (cnt_q != CNT_W'(INIT_LEN)) cnt_q <= cnt_q + 1'b1;
         if (boot_next) z_q <= Z0_V;
         else           z_q <= w_i ? (x_old - OFS_V) : (x_old + OFS_V);
      end
   end

   assign z_o = z_q;

endmodule

// File: rtl/dfn_net.sv
module dfn_net #(
   parameter int   DATA_W     = dfn_pkg::DFN_DATA_W,
   parameter logic W_INIT     = 1'b1,
   parameter int   X_INIT     = 1,
   parameter int   X_STEP     = 2,
   parameter int   Y_INIT     = 0,
   parameter int   Y_STEP     = 1,
   parameter int   Z_INIT     = 0,
   parameter int   Z_OFFSET   = 3,
   parameter int   Z_LAG      = 2,
   parameter int   P_INIT_LEN = 1,
   parameter int   Q_INIT_LEN = 1,
   parameter int   R_INIT_LEN = 2
) (
   input  logic                     clk,
   input  logic                     rst,
   input  logic                     react_en,
   output logic                     w_o,
   output logic signed [DATA_W-1:0] x_o,
   output logic signed [DATA_W-1:0] y_o,
   output logic signed [DATA_W-1:0] z_o
);

   generate
      if (DATA_W < 2) begin : g_bad_width
         $error("dfn_net: DATA_W must be at least 2");
      end
      if (Z_LAG < 1) begin : g_bad_lag
         $error("dfn_net: Z_LAG must be at least 1");
      end
      if (R_INIT_LEN < Z_LAG) begin : g_bad_rlen
         $error("dfn_net: R_INIT_LEN must cover the z look-back");
      end
      if (P_INIT_LEN < 1 || Q_INIT_LEN < 1) begin : g_bad_plen
         $error("dfn_net: start-up windows must be at least one reaction");
      end
   endgenerate

   logic                     w_s;
   logic signed [DATA_W-1:0] x_s;
   logic signed [DATA_W-1:0] y_s;
   logic signed [DATA_W-1:0] z_s;

   dfn_proc_p #(
      .DATA_W   (DATA_W),
      .INIT_LEN (P_INIT_LEN),
      .W_INIT   (W_INIT)
   ) u_p (
      .clk (clk),
      .rst (rst),
      .en  (react_en),
      .y_i (y_s),
      .z_i (z_s),
      .w_o (w_s)
   );

   dfn_proc_q #(
      .DATA_W   (DATA_W),
      .INIT_LEN (Q_INIT_LEN),
      .X_INIT   (X_INIT),
      .X_STEP   (X_STEP),
      .Y_INIT   (Y_INIT),
      .Y_STEP   (Y_STEP)
   ) u_q (
      .clk (clk),
      .rst (rst),
      .en  (react_en),
      .w_i (w_s),
      .x_o (x_s),
      .y_o (y_s)
   );

   dfn_proc_r #(
      .DATA_W   (DATA_W),
      .INIT_LEN (R_INIT_LEN),
      .Z_INIT   (Z_INIT),
      .Z_OFFSET (Z_OFFSET),
      .Z_LAG    (Z_LAG)
   ) u_r (
      .clk (clk),
      .rst (rst),
      .en  (react_en),
      .w_i (w_s),
      .x_i (x_s),
      .z_o (z_s)
   );

   assign w_o = w_s;
   assign x_o = x_s;
   assign y_o = y_s;
   assign z_o = z_s;

endmodule

// File: rtl/dfn_net_chk.sv
module dfn_net_chk #(
   parameter int   DATA_W     = 16,
   parameter logic W_INIT     = 1'b1,
   parameter int   X_INIT     = 1,
   parameter int   X_STEP     = 2,
   parameter int   Y_INIT     = 0,
   parameter int   Y_STEP     = 1,
   parameter int   Z_INIT     = 0,
   parameter int   Z_OFFSET   = 3,
   parameter int   Z_LAG      = 2,
   parameter int   R_INIT_LEN = 2
) (
   input logic                     clk,
   input logic                     rst,
   input logic                     react_en,
   input logic                     w_o,
   input logic signed [DATA_W-1:0] x_o,
   input logic signed [DATA_W-1:0] y_o,
   input logic signed [DATA_W-1:0] z_o
);

   localparam int CW  = $clog2(R_INIT_LEN + 1);
   localparam int HD  = (Z_LAG >= 2) ? Z_LAG - 1 : 1;
   localparam int HI  = (Z_LAG >= 2) ? Z_LAG - 2 : 0;
   localparam logic signed [DATA_W-1:0] X0_V  = DATA_W'(X_INIT);
   localparam logic signed [DATA_W-1:0] XS_V  = DATA_W'(X_STEP);
   localparam logic signed [DATA_W-1:0] Y0_V  = DATA_W'(Y_INIT);
   localparam logic signed [DATA_W-1:0] YS_V  = DATA_W'(Y_STEP);
   localparam logic signed [DATA_W-1:0] Z0_V  = DATA_W'(Z_INIT);
   localparam logic signed [DATA_W-1:0] OFS_V = DATA_W'(Z_OFFSET);

   logic [CW-1:0]            seen_q;
   logic signed [DATA_W-1:0] hist_q [HD];
   logic signed [DATA_W-1:0] x_lag;

   always_ff @(posedge clk) begin
      if (rst) begin
         seen_q <= '0;
         for (int i = 0; i < HD; i++) hist_q[i] <= '0;
      end else if (react_en) begin
         if (seen_q != CW'(R_INIT_LEN)) seen_q <= seen_q + 1'b1;
         hist_q[0] <= x_o;
         for (int i = 1; i < HD; i++) hist_q[i] <= hist_q[i-1];
      end
   end

   assign x_lag = (Z_LAG == 1) ? x_o : hist_q[HI];

   assert_reset_state_R1: assert property (@(posedge clk)
      rst |=> (w_o == W_INIT && x_o == X0_V && y_o == Y0_V && z_o == Z0_V));

   assert_x_ramp_R2: assert property (@(posedge clk) disable iff (rst)
      react_en |=> x_o == $past(x_o) + XS_V);

   assert_y_follow_R3: assert property (@(posedge clk) disable iff (rst)
      react_en |=> y_o == ($past(w_o) ? $past(x_o) + YS_V : $past(x_o) - YS_V));

   assert_w_compare_R4: assert property (@(posedge clk) disable iff (rst)
      react_en |=> w_o == ($past(y_o) > $past(z_o)));

   assert_z_startup_R5: assert property (@(posedge clk) disable iff (rst)
      (react_en && seen_q < CW'(R_INIT_LEN - 1)) |=> z_o == Z0_V);

   assert_z_lagged_R5: assert property (@(posedge clk) disable iff (rst)
      (react_en && seen_q >= CW'(R_INIT_LEN - 1)) |=>
         z_o == ($past(w_o) ? $past(x_lag) - OFS_V : $past(x_lag) + OFS_V));

   assert_freeze_R6: assert property (@(posedge clk) disable iff (rst)
      !react_en |=> ($stable(w_o) && $stable(x_o) && $stable(y_o) && $stable(z_o)));

endmodule

bind dfn_net dfn_net_chk #(
   .DATA_W     (DATA_W),
   .W_INIT     (W_INIT),
   .X_INIT     (X_INIT),
   .X_STEP     (X_STEP),
   .Y_INIT     (Y_INIT),
   .Y_STEP     (Y_STEP),
   .Z_INIT     (Z_INIT),
   .Z_OFFSET   (Z_OFFSET),
   .Z_LAG      (Z_LAG),
   .R_INIT_LEN (R_INIT_LEN)
) u_dfn_net_chk (
   .clk      (clk),
   .rst      (rst),
   .react_en (react_en),
   .w_o      (w_o),
   .x_o      (x_o),
   .y_o      (y_o),
   .z_o      (z_o)
);

// File: tb/test_dfn_net.sv
module test_dfn_net;

   localparam int PERIOD = 10;
   localparam int DW     = 16;
   localparam int NREF   = 8;
   localparam int NLONG  = 16400;

   // Reference reactions 0..7: {w, x, y, z}
   localparam logic signed [DW-1:0] REF_X [NREF] = '{1, 3, 5, 7, 9, 11, 13, 15};
   localparam logic signed [DW-1:0] REF_Y [NREF] = '{0, 2, 2, 6, 6, 10, 10, 14};
   localparam logic signed [DW-1:0] REF_Z [NREF] = '{0, 0, 4, 0, 8, 4, 12, 8};
   localparam logic                 REF_W [NREF] = '{1, 0, 1, 0, 1, 0, 1, 0};

   logic                 clk = 1'b0;
   logic                 rst;
   logic                 react_en;
   logic                 w_o;
   logic signed [DW-1:0] x_o, y_o, z_o;

   int n_cmp = 0;
   int n_bad = 0;

   // reference model state
   logic                 m_w;
   logic signed [DW-1:0] m_x, m_y, m_z, m_xp;
   int                   wraps = 0;

   always #(PERIOD/2) clk = ~clk;

   dfn_net i_dfn_net (
      .clk      (clk),
      .rst      (rst),
      .react_en (react_en),
      .w_o      (w_o),
      .x_o      (x_o),
      .y_o      (y_o),
      .z_o      (z_o)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
      end
   endtask

   task automatic step(input logic en);
      @(negedge clk);
      react_en = en;
      @(posedge clk);
      #1;
   endtask

   task automatic model_advance();
      logic                 nw;
      logic signed [DW-1:0] nx, ny, nz;
      nw = (m_y > m_z);
      nx = m_x + 16'sd2;
      ny = m_w ? m_x + 16'sd1 : m_x - 16'sd1;
      nz = m_w ? m_xp - 16'sd3 : m_xp + 16'sd3;
      m_xp = m_x;
      m_w = nw; m_x = nx; m_y = ny; m_z = nz;
   endtask

   task automatic compare_model();
      check(w_o == m_w, "R4 w recurrence", int'(w_o), int'(m_w));
      check(x_o == m_x, "R2 x ramp",       int'(x_o), int'(m_x));
      check(y_o == m_y, "R3 y recurrence", int'(y_o), int'(m_y));
      check(z_o == m_z, "R5 z recurrence", int'(z_o), int'(m_z));
   endtask

   initial begin : watchdog
      #(PERIOD * 200000);
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin : main
      logic signed [DW-1:0] old_x;
      rst      = 1'b1;
      react_en = 1'b0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst = 1'b0;
      #1;

      // R1: reset state (reaction 0)
      check(w_o == 1'b1, "R1 reset w", int'(w_o), 1);
      check(x_o == 16'sd1, "R1 reset x", int'(x_o), 1);
      check(y_o == 16'sd0, "R1 reset y", int'(y_o), 0);
      check(z_o == 16'sd0, "R1 reset z", int'(z_o), 0);

      // R7: reference table walk, reactions 1..7
      for (int r = 1; r < NREF; r++) begin
         step(1'b1);
         check(w_o == REF_W[r], "R7 table w", int'(w_o), int'(REF_W[r]));
         check(x_o == REF_X[r], "R7 table x", int'(x_o), int'(REF_X[r]));
         check(y_o == REF_Y[r], "R7 table y", int'(y_o), int'(REF_Y[r]));
         check(z_o == REF_Z[r], "R7 table z", int'(z_o), int'(REF_Z[r]));
      end

      // R6: freeze for several cycles
      for (int k = 0; k < 4; k++) begin
         step(1'b0);
         check(w_o == REF_W[NREF-1] && x_o == REF_X[NREF-1] &&
               y_o == REF_Y[NREF-1] && z_o == REF_Z[NREF-1],
               "R6 freeze hold x", int'(x_o), int'(REF_X[NREF-1]));
      end

      // Long model-driven run, interleaved freezes, through the x wrap (R8)
      m_w = REF_W[NREF-1]; m_x = REF_X[NREF-1];
      m_y = REF_Y[NREF-1]; m_z = REF_Z[NREF-1]; m_xp = REF_X[NREF-2];
      for (int k = 0; k < NLONG; k++) begin
         if (k % 37 == 5) begin
            step(1'b0);
            check(w_o == m_w && x_o == m_x && y_o == m_y && z_o == m_z,
                  "R6 freeze hold z", int'(z_o), int'(m_z));
         end
         step(1'b1);
         old_x = m_x;
         model_advance();
         compare_model();
         if (m_x < old_x) begin
            wraps++;
            check(x_o == -16'sd32767, "R8 x wrap", int'(x_o), -32767);
         end
      end
      check(wraps == 1, "R8 wrap seen", wraps, 1);

      // R1 again: reset in the middle of a run, with enable still high
      @(negedge clk);
      rst = 1'b1;
      react_en = 1'b1;
      @(posedge clk);
      #1;
      check(w_o == 1'b1 && x_o == 16'sd1 && y_o == 16'sd0 && z_o == 16'sd0,
            "R1 mid-run reset x", int'(x_o), 1);
      @(negedge clk);
      rst = 1'b0;
      @(posedge clk);
      #1;
      // reaction 1 after reset: z still in its start-up window
      check(z_o == 16'sd0, "R5 z start-up after reset", int'(z_o), 0);
      check(y_o == 16'sd2, "R3 y after reset", int'(y_o), 2);
      check(w_o == 1'b0, "R4 w after reset", int'(w_o), 0);
      step(1'b1);
      check(z_o == 16'sd4, "R5 first lagged z", int'(z_o), 4);
      check(x_o == 16'sd5, "R2 x after reset", int'(x_o), 5);

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule